// File: doc/BRIEF.md
# SD Host Block-Gap DMA Engine

This block is the data mover of an SD host controller. Once given a starting system address, a block length in words and a block count, it moves every data word between the card data path and system memory with no help from the processor. Memory addresses run upward one word at a time from the programmed start. A direction bit chooses between card-to-memory (memory writes) and memory-to-card (memory reads). Runs of one block and runs of many blocks are both accepted. Each run carries exactly one SD command's worth of data, and a run of unbounded length is refused.

The engine can park itself cleanly on a block boundary when a stop-at-gap level is held. It then reports one block-gap event and waits. Either a continue request or a resume-command pulse releases it, and it picks up at the next sequential address with the remaining blocks still owed. An SD bus error or a DAT-line software reset ends an active run at once: the engine reports an abort event and returns to idle. The engine uses only the DAT-path data and memory ports. The command path is never held off by it.

The controller has six states: IDLE (waiting for a start), MOVE (transferring words), GAP_MARK (one cycle that flags the gap), GAP_HOLD (parked), FINISH (one cycle that flags completion) and ABORT (one cycle that flags the abort). The transitions are as follows:
- IDLE→MOVE on an accepted start.
- MOVE→FINISH when the last word of the last block is accepted.
- MOVE→GAP_MARK when a block other than the last ends while stop-at-gap is high.
- GAP_MARK→GAP_HOLD when no release arrives.
- GAP_MARK or GAP_HOLD→MOVE on a release.
- MOVE, GAP_MARK or GAP_HOLD→ABORT on an error or a reset.
- FINISH→IDLE and ABORT→IDLE unconditionally.

Top module: `sdgap_dma`

## Requirements
- R1: After reset the engine is idle. busy, mem_req, xfer_done, gap_event, abort_event and start_refused are all low.
- R2: An accepted start makes the first memory beat use cfg_addr. Each accepted beat (mem_req and mem_ready both high) moves mem_addr up by 4 bytes. A stalled request keeps mem_addr unchanged.
- R3: When cfg_dir is 1 (card to memory), mem_we is 1 and mem_wdata carries dp_in_data. dp_in_ready is high exactly in the cycles in which a beat is accepted.
- R4: When cfg_dir is 0 (memory to card), mem_we is 0. dp_out_valid is high exactly on accepted beats, and dp_out_data then equals mem_rdata.
- R5: A run moves exactly cfg_blk_words × cfg_blk_count words, a single block included. xfer_done is high for exactly one cycle, the cycle after the final beat, and then the engine is idle.
- R6: In idle, a start with cfg_infinite set, a zero block count or a zero block length raises start_refused in that cycle. The engine stays idle and makes no memory request.
- R7: When a block that is not the last ends while stop_gap is high, gap_event is high for one cycle after that block's final beat. After that, no memory request is made until a release arrives.
- R8: A continue_req or resume_cmd pulse releases a parked engine. It continues at the next sequential address with the outstanding blocks still owed, and it parks again at the next boundary if stop_gap is still high.
- R9: A bus_err while a run is active (moving or parked) blocks mem_req in that same cycle. abort_event is high for one cycle in the next cycle, then the engine is idle, and no further beat occurs.
- R10: A dat_reset while a run is active, parked included, behaves the same as R9.
- R11: bus_err or dat_reset while idle raise no abort_event and leave a later start working normally.
- R12: A start pulse while a run is active is ignored. The address sequence and the word total of the active run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| cfg_addr | input | AW | First system address |
| cfg_blk_words | input | BW | Words per block |
| cfg_blk_count | input | CW | Number of blocks |
| cfg_dir | input | 1 | 1 = card to memory, 0 = memory to card |
| cfg_infinite | input | 1 | Unbounded-length mode requested (refused) |
| stop_gap | input | 1 | Stop-at-block-gap level |
| continue_req | input | 1 | Continue pulse |
| resume_cmd | input | 1 | Resume-command pulse |
| bus_err | input | 1 | SD bus error |
| dat_reset | input | 1 | DAT-line software reset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | DW | Memory read data, valid with mem_ready |
| dp_in_valid | input | 1 | Card data word available |
| dp_in_data | input | DW | Card data word |
| dp_in_ready | output | 1 | Card data word consumed |
| dp_out_valid | output | 1 | Word delivered toward card |
| dp_out_data | output | DW | Word toward card |
| dp_out_ready | input | 1 | Card path can take a word |
| busy | output | 1 | Run in progress |
| xfer_done | output | 1 | Transfer-complete event |
| gap_event | output | 1 | Block-gap event |
| abort_event | output | 1 | Error-abort event |
| start_refused | output | 1 | Start rejected |

## Verification
The hardest behaviour to reach is a release or a reset that lands while the engine is parked in GAP_HOLD. Reaching it needs stop_gap held through a whole block, then a wait for the gap event, and only then a pulse. The stimulus holds stop_gap before starting and waits on the observed gap event. It then checks that the beat count and the address are frozen. After that it pulses continue (still stopped), resume (stop cleared) or dat_reset, and checks that the address carries on or the abort follows. Errors in the middle of a run are placed after a counted number of beats while mem_ready stalls in a fixed pattern.

// File: rtl/sdgap_pkg.sv
package sdgap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MOVE,
        ST_GAP_MARK,
        ST_GAP_HOLD,
        ST_FINISH,
        ST_ABORT
    } sdgap_state_e;
endpackage

// File: rtl/sdgap_addr_gen.sv
module sdgap_addr_gen #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          beat,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (beat) begin
            addr <= addr + STEP;
        end
    end
endmodule

// File: rtl/sdgap_blk_ctr.sv
module sdgap_blk_ctr #(
    parameter int BW = 10,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] blk_words,
    input  logic [CW-1:0] blk_count,
    input  logic          beat,
    output logic          block_end,
    output logic          last_block
);
    logic [BW-1:0] size_q;
    logic [BW-1:0] wleft_q;
    logic [CW-1:0] bleft_q;

    assign block_end  = beat && (wleft_q == BW'(1));
    assign last_block = (bleft_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= '0;
            wleft_q <= '0;
            bleft_q <= '0;
        end else if (load) begin
            size_q  <= blk_words;
            wleft_q <= blk_words;
            bleft_q <= blk_count;
        end else if (block_end) begin
            wleft_q <= size_q;
            bleft_q <= bleft_q - CW'(1);
        end else if (beat) begin
            wleft_q <= wleft_q - BW'(1);
        end
    end
endmodule

// File: rtl/sdgap_fsm.sv
module sdgap_fsm
    import sdgap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cfg_ok,
    input  logic block_end,
    input  logic last_block,
    input  logic stop_gap,
    input  logic release_req,
    input  logic abort_in,
    output logic load,
    output logic refused,
    output logic move,
    output logic busy,
    output logic xfer_done,
    output logic gap_event,
    output logic abort_event
);
    sdgap_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start && cfg_ok) nxt = ST_MOVE;
            end
            ST_MOVE: begin
                if (abort_in)                     nxt = ST_ABORT;
                else if (block_end && last_block) nxt = ST_FINISH;
                else if (block_end && stop_gap)   nxt = ST_GAP_MARK;
            end
            ST_GAP_MARK, ST_GAP_HOLD: begin
                if (abort_in)         nxt = ST_ABORT;
                else if (release_req) nxt = ST_MOVE;
                else                  nxt = ST_GAP_HOLD;
            end
            ST_FINISH: nxt = ST_IDLE;
            ST_ABORT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load        = (state == ST_IDLE) && start && cfg_ok;
        refused     = (state == ST_IDLE) && start && !cfg_ok;
        move        = (state == ST_MOVE);
        busy        = (state != ST_IDLE);
        xfer_done   = (state == ST_FINISH);
        gap_event   = (state == ST_GAP_MARK);
        abort_event = (state == ST_ABORT);
    end
endmodule

// File: rtl/sdgap_dma.sv
module sdgap_dma #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int BW = 10,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_addr,
    input  logic [BW-1:0] cfg_blk_words,
    input  logic [CW-1:0] cfg_blk_count,
    input  logic          cfg_dir,
    input  logic          cfg_infinite,
    input  logic          stop_gap,
    input  logic          continue_req,
    input  logic          resume_cmd,
    input  logic          bus_err,
    input  logic          dat_reset,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dp_in_valid,
    input  logic [DW-1:0] dp_in_data,
    output logic          dp_in_ready,
    output logic          dp_out_valid,
    output logic [DW-1:0] dp_out_data,
    input  logic          dp_out_ready,
    output logic          busy,
    output logic          xfer_done,
    output logic          gap_event,
    output logic          abort_event,
    output logic          start_refused
);
    localparam int WORD_BYTES = DW / 8;

    logic cfg_ok, load, move, beat, block_end, last_block, abort_in, dir_q;

    assign cfg_ok   = !cfg_infinite && (cfg_blk_words != '0) && (cfg_blk_count != '0);
    assign abort_in = bus_err || dat_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (load) begin
            dir_q <= cfg_dir;
        end
    end

    assign mem_req      = move && !abort_in && (dir_q ? dp_in_valid : dp_out_ready);
    assign beat         = mem_req && mem_ready;
    assign mem_we       = dir_q;
    assign mem_wdata    = dp_in_data;
    assign dp_in_ready  = beat && dir_q;
    assign dp_out_valid = beat && !dir_q;
    assign dp_out_data  = mem_rdata;

    sdgap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_ok      (cfg_ok),
        .block_end   (block_end),
        .last_block  (last_block),
        .stop_gap    (stop_gap),
        .release_req (continue_req || resume_cmd),
        .abort_in    (abort_in),
        .load        (load),
        .refused     (start_refused),
        .move        (move),
        .busy        (busy),
        .xfer_done   (xfer_done),
        .gap_event   (gap_event),
        .abort_event (abort_event)
    );

    sdgap_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .base  (cfg_addr),
        .beat  (beat),
        .addr  (mem_addr)
    );

    sdgap_blk_ctr #(.BW(BW), .CW(CW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .blk_words  (cfg_blk_words),
        .blk_count  (cfg_blk_count),
        .beat       (beat),
        .block_end  (block_end),
        .last_block (last_block)
    );
endmodule

// File: rtl/sdgap_dma_chk.sv
module sdgap_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_err,
    input logic          dat_reset,
    input logic          continue_req,
    input logic          resume_cmd,
    input logic          mem_req,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          xfer_done,
    input logic          gap_event,
    input logic          abort_event,
    input logic          start_refused
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (mem_addr == $past(mem_addr) + AW'(4)));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!busy && !xfer_done));

    assert_refuse_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_refused |=> !busy);

    assert_gap_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_event && !continue_req && !resume_cmd) |=> !mem_req);

    assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && busy && !xfer_done && !abort_event) |=> abort_event);

    assert_err_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !mem_req);

    assert_rst_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_reset && busy && !xfer_done && !abort_event) |=> abort_event);

    assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_done, gap_event, abort_event}));
endmodule

bind sdgap_dma sdgap_dma_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_err       (bus_err),
    .dat_reset     (dat_reset),
    .continue_req  (continue_req),
    .resume_cmd    (resume_cmd),
    .mem_req       (mem_req),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .busy          (busy),
    .xfer_done     (xfer_done),
    .gap_event     (gap_event),
    .abort_event   (abort_event),
    .start_refused (start_refused)
);

// File: tb/sdgap_dma_bench.sv
module sdgap_dma_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 10;
    localparam int CW = 16;
    localparam logic [31:0] KEY = 32'hA5A5_0000;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0, cfg_dir = 0, cfg_infinite = 0;
    logic [AW-1:0] cfg_addr = '0;
    logic [BW-1:0] cfg_blk_words = '0;
    logic [CW-1:0] cfg_blk_count = '0;
    logic stop_gap = 0, continue_req = 0, resume_cmd = 0, bus_err = 0, dat_reset = 0;
    logic mem_req, mem_we, mem_ready, dp_in_ready, dp_out_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dp_out_data;
    logic dp_in_valid = 1, dp_out_ready = 1;
    logic [DW-1:0] dp_in_data = 32'h100;
    logic busy, xfer_done, gap_event, abort_event, start_refused;
    logic ready_mode = 0;
    logic [1:0] cyc = 0;

    int n_chk = 0, n_err = 0;
    int beats = 0, done_cnt = 0, gap_cnt = 0, abort_cnt = 0, ref_cnt = 0;
    logic [AW-1:0] exp_addr = '0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 2'd1;
    assign mem_ready = ready_mode ? (cyc != 2'b00) : 1'b1;
    assign mem_rdata = mem_addr ^ KEY;

    sdgap_dma #(.AW(AW), .DW(DW), .BW(BW), .CW(CW)) u_sdgap_dma (.*);

    task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ready) begin
                beats++;
                chk("R2 beat address", mem_addr == exp_addr, mem_addr, exp_addr);
                if (mem_we) begin
                    chk("R3 write data", dp_in_ready && mem_wdata == dp_in_data, mem_wdata, dp_in_data);
                    dp_in_data = dp_in_data + 1;
                end else begin
                    chk("R4 read data", dp_out_valid && dp_out_data == (exp_addr ^ KEY), dp_out_data, exp_addr ^ KEY);
                end
                exp_addr = exp_addr + 4;
            end else if (dp_in_ready || dp_out_valid) begin
                chk("R3/R4 strobe without beat", 0, {dp_in_ready, dp_out_valid}, 0);
            end
            if (xfer_done) done_cnt++;
            if (gap_event) gap_cnt++;
            if (abort_event) abort_cnt++;
            if (start_refused) ref_cnt++;
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic pulse_start();
        tick(); start = 1; tick(); start = 0;
    endtask

    task automatic setup(input logic [AW-1:0] a, input int w, input int c, input logic d);
        cfg_addr = a; cfg_blk_words = BW'(w); cfg_blk_count = CW'(c); cfg_dir = d;
        exp_addr = a;
    endtask

    task automatic wait_cnt(ref int cnt, input int target);
        for (int k = 0; k < 3000 && cnt < target; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", !busy, busy, 0);
        chk("R1 req", !mem_req, mem_req, 0);
        chk("R1 events", {xfer_done, gap_event, abort_event, start_refused} == 0,
            {xfer_done, gap_event, abort_event, start_refused}, 0);
    endtask

    task automatic t_run(input logic [AW-1:0] a, input int w, input int c, input logic d, input logic stall);
        int b0, d0;
        b0 = beats; d0 = done_cnt; ready_mode = stall;
        setup(a, w, c, d);
        pulse_start();
        wait_cnt(done_cnt, d0 + 1);
        chk("R5 word total", beats - b0 == w * c, beats - b0, w * c);
        chk("R5 one done", done_cnt - d0 == 1, done_cnt - d0, 1);
        chk("R5 idle after", !busy, busy, 0);
        chk("R2 final address", mem_addr == a + AW'(4 * w * c), mem_addr, a + AW'(4 * w * c));
        ready_mode = 0;
    endtask

    task automatic t_refuse();
        int b0, r0;
        b0 = beats; r0 = ref_cnt;
        setup(32'h200, 4, 2, 1); cfg_infinite = 1;
        pulse_start();
        cfg_infinite = 0; cfg_blk_count = 0;
        pulse_start();
        cfg_blk_count = 2; cfg_blk_words = 0;
        pulse_start();
        repeat (5) @(negedge clk);
        chk("R6 refused count", ref_cnt - r0 == 3, ref_cnt - r0, 3);
        chk("R6 idle", !busy, busy, 0);
        chk("R6 no beats", beats == b0, beats - b0, 0);
    endtask

    task automatic t_gap();
        int b0, g0, d0;
        b0 = beats; g0 = gap_cnt; d0 = done_cnt;
        setup(32'h3000, 2, 3, 1); stop_gap = 1;
        pulse_start();
        wait_cnt(gap_cnt, g0 + 1);
        repeat (10) @(negedge clk);
        chk("R7 one gap event", gap_cnt - g0 == 1, gap_cnt - g0, 1);
        chk("R7 parked beats", beats - b0 == 2, beats - b0, 2);
        chk("R7 no request", !mem_req && busy, {mem_req, busy}, 1);
        tick(); continue_req = 1; tick(); continue_req = 0;
        wait_cnt(gap_cnt, g0 + 2);
        repeat (3) @(negedge clk);
        chk("R8 continue one block", beats - b0 == 4, beats - b0, 4);
        chk("R8 address held", mem_addr == 32'h3010, mem_addr, 32'h3010);
        stop_gap = 0;
        tick(); resume_cmd = 1; tick(); resume_cmd = 0;
        wait_cnt(done_cnt, d0 + 1);
        chk("R8 resume finishes", beats - b0 == 6 && done_cnt - d0 == 1, beats - b0, 6);
        chk("R8 final address", mem_addr == 32'h3018, mem_addr, 32'h3018);
    endtask

    task automatic t_buserr();
        int b0, a0, b1;
        b0 = beats; a0 = abort_cnt; ready_mode = 1;
        setup(32'h5000, 8, 4, 0);
        pulse_start();
        wait_cnt(beats, b0 + 5);
        tick(); bus_err = 1; tick(); bus_err = 0;
        repeat (3) @(negedge clk);
        chk("R9 abort event", abort_cnt - a0 == 1, abort_cnt - a0, 1);
        chk("R9 idle", !busy, busy, 0);
        b1 = beats;
        repeat (10) @(negedge clk);
        chk("R9 no beats after", beats == b1, beats - b1, 0);
        chk("R9 partial", beats - b0 < 32, beats - b0, 32);
        ready_mode = 0;
    endtask

    task automatic t_datrst();
        int g0, a0, b1;
        g0 = gap_cnt; a0 = abort_cnt;
        setup(32'h6000, 2, 2, 1); stop_gap = 1;
        pulse_start();
        wait_cnt(gap_cnt, g0 + 1);
        tick(); dat_reset = 1; tick(); dat_reset = 0;
        repeat (3) @(negedge clk);
        stop_gap = 0;
        chk("R10 abort from park", abort_cnt - a0 == 1, abort_cnt - a0, 1);
        chk("R10 idle", !busy, busy, 0);
        b1 = beats;
        tick(); continue_req = 1; tick(); continue_req = 0;
        repeat (5) @(negedge clk);
        chk("R10 no beats after", beats == b1, beats - b1, 0);
    endtask

    task automatic t_idle_err();
        int a0;
        a0 = abort_cnt;
        tick(); bus_err = 1; dat_reset = 1; tick(); bus_err = 0; dat_reset = 0;
        repeat (3) @(negedge clk);
        chk("R11 no abort in idle", abort_cnt == a0, abort_cnt - a0, 0);
        t_run(32'h7000, 3, 1, 0, 0);
    endtask

    task automatic t_busy_start();
        int b0, d0;
        b0 = beats; d0 = done_cnt;
        setup(32'h4000, 3, 2, 1);
        pulse_start();
        wait_cnt(beats, b0 + 2);
        cfg_addr = 32'h9000; cfg_blk_count = 9;
        pulse_start();
        wait_cnt(done_cnt, d0 + 1);
        chk("R12 total unchanged", beats - b0 == 6, beats - b0, 6);
        chk("R12 final address", mem_addr == 32'h4018, mem_addr, 32'h4018);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_run(32'h1000, 4, 3, 1, 1);
        t_run(32'h2000, 4, 3, 0, 1);
        t_run(32'h2800, 1, 1, 0, 0);
        t_refuse();
        t_gap();
        t_buserr();
        t_datrst();
        t_idle_err();
        t_busy_start();
        finish_up();
    end
endmodule